// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block is the device-side engine that walks a transmit ring. Software builds 16-byte descriptors in memory and hands each one over by setting its ownership bit. A write to the poll register then starts a scan. The engine reads the descriptor at its current ring index through a plain request/response memory port. For each valid owned descriptor it issues a send command to a frame sender. That command carries the 64-bit buffer address and the frame length, on a valid/ready handshake. When the sender signals done, the engine writes the status word back with ownership cleared, moves to the next slot and keeps scanning. The scan stops at the first descriptor that is not owned.

The ring has no fixed size. A per-descriptor end-of-ring flag sends the index back to the start of the ring. The ring base is set through the same register port. Writing it also restarts the ring at index 0. Length padding to the 60-byte minimum is done by software; the engine forwards the length field unchanged.

Top module: `txq_fetch_engine`

## Requirements
- R1: After a synchronous active-low reset the engine is idle. `busy`, `send_valid`, `mem_req_valid` and `fmt_err` are low, and the ring index is 0, so the first scan reads the word at the base address.
- R2: A scan starts only on a register write to offset 0x38 whose low byte is 0x40. A write of any other value, or a write to any other offset, starts nothing. A poll write while the engine is busy has no effect.
- R3: A descriptor occupies 16 bytes at base + 16 × index. Its status word is at +0, the buffer address low word is at +8 and the high word is at +12. The word at +4 is never read.
- R4: If the status word read has bit 31 (ownership) clear, the engine returns to idle without writing and without moving the index. The next scan reads the same descriptor.
- R5: An owned descriptor with status bits 29 and 28 both set produces one send command. Its `send_addr` is {high word, low word} and its `send_len` is status bits 15:0. The command is held on `send_valid` with stable fields until `send_ready`.
- R6: After `send_done`, the status word is written back to +0 with bit 31 cleared and every other bit unchanged.
- R7: An owned descriptor whose bits 29 and 28 are not both 1 is not sent. `fmt_err` pulses for one cycle, and the status word is written back with bit 31 cleared.
- R8: After each write-back the index advances by one, or returns to 0 when status bit 30 (end of ring) was set. The scan then continues with the next descriptor.
- R9: A write to offset 0x20 while idle loads the ring base, with its low four bits forced to zero, and resets the index to 0. Writes to offset 0x20 while busy are dropped.
- R10: A memory request, once raised, stays raised with stable address, direction and write data until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | 32 | Read response data |
| send_valid | output | 1 | Send command valid |
| send_ready | input | 1 | Sender accepts command |
| send_addr | output | 64 | Frame buffer address |
| send_len | output | 16 | Frame length in bytes |
| send_done | input | 1 | Sender finished the frame |
| busy | output | 1 | Engine is scanning |
| fmt_err | output | 1 | One-cycle pulse on a bad segment combination |

## Verification
Every cycle, the assertions check the following:
- the send command and the memory request hold steady under back-pressure;
- no write-back ever carries the ownership bit;
- an error pulse never coincides with a send;
- an idle engine drives no request;
- request addresses are word-aligned.

Only the bench scenarios can show the ring-level behaviour:
- which descriptors are sent and which are skipped;
- that the index stays put on a non-owned descriptor;
- that the end-of-ring flag wraps the index;
- that a base write restarts at slot 0;
- that wrong poll values are ignored.

// File: rtl/txq_pkg.sv
// Package: shared constants and types of the transmit descriptor fetch engine.
// Assumes 32-bit descriptor words and a 16-byte descriptor.
package txq_pkg;
    localparam int DATA_W  = 32;
    localparam int LEN_W   = 16;
    localparam int OWN_BIT = 31;
    localparam int EOR_BIT = 30;
    localparam int FS_BIT  = 29;
    localparam int LS_BIT  = 28;

    // word offsets inside a descriptor (in 32-bit words)
    localparam logic [1:0] W_STATUS = 2'd0;
    localparam logic [1:0] W_BUF_LO = 2'd2;
    localparam logic [1:0] W_BUF_HI = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RREQ,
        S_RWAIT,
        S_SEND,
        S_DONE,
        S_WREQ
    } eng_state_t;
endpackage

// File: rtl/txq_regs.sv
// Register decode: holds the ring base and turns writes into a poll kick and
// a base-load strobe. Assumes a single-cycle write strobe; base loads are
// taken only while the engine is idle.
module txq_regs
    import txq_pkg::*;
#(
    parameter int         REG_AW   = 8,
    parameter logic [7:0] POLL_OFS = 8'h38,
    parameter logic [7:0] BASE_OFS = 8'h20,
    parameter logic [7:0] KICK_VAL = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] base_q,
    output logic              kick,
    output logic              base_wr
);
    // Decode the poll kick and an accepted base write.
    always_comb begin
        kick    = reg_wr_en && (reg_addr == REG_AW'(POLL_OFS)) && (reg_wdata[7:0] == KICK_VAL);
        base_wr = reg_wr_en && (reg_addr == REG_AW'(BASE_OFS)) && idle;
    end

    // Hold the 16-byte aligned ring base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_wr) begin
            base_q <= {reg_wdata[DATA_W-1:4], 4'b0000};
        end
    end
endmodule

// File: rtl/txq_ring_ptr.sv
// Ring index and address generator. The index clears on a base load, steps by
// one per finished descriptor, and returns to 0 on an end-of-ring step.
// Assumes IDX_W + 4 <= 32.
module txq_ring_ptr
    import txq_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              wrap,
    input  logic [DATA_W-1:0] base,
    input  logic [1:0]        word_sel,
    output logic [DATA_W-1:0] addr
);
    localparam int DESC_SH = 4;

    logic [IDX_W-1:0] index_q;

    // Update the ring index.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            index_q <= '0;
        end else if (step) begin
            index_q <= wrap ? '0 : index_q + 1'b1;
        end
    end

    // Form the byte address of the selected descriptor word.
    always_comb begin
        addr = base + (DATA_W'(index_q) << DESC_SH) + DATA_W'({word_sel, 2'b00});
    end
endmodule

// File: rtl/txq_desc_decode.sv
// Status word decoder: splits out ownership, end-of-ring, segment validity and
// length, and forms the write-back word with ownership cleared. Pure logic.
module txq_desc_decode
    import txq_pkg::*;
(
    input  logic [DATA_W-1:0] status,
    output logic              own,
    output logic              eor,
    output logic              frame_ok,
    output logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] wb_status
);
    // Field extraction and write-back word.
    always_comb begin
        own       = status[OWN_BIT];
        eor       = status[EOR_BIT];
        frame_ok  = status[FS_BIT] && status[LS_BIT];
        len       = status[LEN_W-1:0];
        wb_status = status;
        wb_status[OWN_BIT] = 1'b0;
    end
endmodule

// File: rtl/txq_fetch_engine.sv
// Transmit descriptor fetch engine (top). On a poll kick it reads descriptors
// from the ring, sends each valid owned one to the frame sender, writes the
// status back with ownership cleared and advances, until it meets a
// descriptor it does not own. Assumes read responses arrive one or more
// cycles after request acceptance, and that writes complete on acceptance.
module txq_fetch_engine
    import txq_pkg::*;
#(
    parameter int IDX_W  = 12,
    parameter int REG_AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_write,
    output logic [DATA_W-1:0]   mem_req_addr,
    output logic [DATA_W-1:0]   mem_req_wdata,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_rdata,
    output logic                send_valid,
    input  logic                send_ready,
    output logic [2*DATA_W-1:0] send_addr,
    output logic [LEN_W-1:0]    send_len,
    input  logic                send_done,
    output logic                busy,
    output logic                fmt_err
);
    eng_state_t        state;
    logic [1:0]        wsel;
    logic [DATA_W-1:0] stat_q, lo_q, hi_q;
    logic [DATA_W-1:0] base_q;
    logic              kick, base_wr;

    logic              rsp_own, rsp_eor, rsp_ok;
    logic [LEN_W-1:0]  rsp_len;
    logic [DATA_W-1:0] rsp_wb;
    logic              cur_own, cur_eor, cur_ok;
    logic [LEN_W-1:0]  cur_len;
    logic [DATA_W-1:0] cur_wb;
    logic              step;
    logic [1:0]        word_sel;

    txq_regs #(.REG_AW(REG_AW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (state == S_IDLE),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .base_q    (base_q),
        .kick      (kick),
        .base_wr   (base_wr)
    );

    // decoder on the incoming read word (drives branch decisions)
    txq_desc_decode rsp_dec_i (
        .status    (mem_rsp_rdata),
        .own       (rsp_own),
        .eor       (rsp_eor),
        .frame_ok  (rsp_ok),
        .len       (rsp_len),
        .wb_status (rsp_wb)
    );

    // decoder on the captured status word (drives send and write-back)
    txq_desc_decode cur_dec_i (
        .status    (stat_q),
        .own       (cur_own),
        .eor       (cur_eor),
        .frame_ok  (cur_ok),
        .len       (cur_len),
        .wb_status (cur_wb)
    );

    txq_ring_ptr #(.IDX_W(IDX_W)) ptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (base_wr),
        .step     (step),
        .wrap     (cur_eor),
        .base     (base_q),
        .word_sel (word_sel),
        .addr     (mem_req_addr)
    );

    // Select the word to address and the step condition for the index.
    always_comb begin
        word_sel = (state == S_WREQ) ? W_STATUS : wsel;
        step     = (state == S_WREQ) && mem_req_ready;
    end

    // Sequence the scan: read status, read buffer words, send, write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            wsel    <= W_STATUS;
            stat_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            fmt_err <= 1'b0;
        end else begin
            fmt_err <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (kick) begin
                        wsel  <= W_STATUS;
                        state <= S_RREQ;
                    end
                end
                S_RREQ: begin
                    if (mem_req_ready) state <= S_RWAIT;
                end
                S_RWAIT: begin
                    if (mem_rsp_valid) begin
                        unique case (wsel)
                            W_STATUS: begin
                                stat_q <= mem_rsp_rdata;
                                if (!rsp_own) begin
                                    state <= S_IDLE;
                                end else if (!rsp_ok) begin
                                    fmt_err <= 1'b1;
                                    state   <= S_WREQ;
                                end else begin
                                    wsel  <= W_BUF_LO;
                                    state <= S_RREQ;
                                end
                            end
                            W_BUF_LO: begin
                                lo_q  <= mem_rsp_rdata;
                                wsel  <= W_BUF_HI;
                                state <= S_RREQ;
                            end
                            default: begin
                                hi_q  <= mem_rsp_rdata;
                                state <= S_SEND;
                            end
                        endcase
                    end
                end
                S_SEND: begin
                    if (send_ready) state <= S_DONE;
                end
                S_DONE: begin
                    if (send_done) state <= S_WREQ;
                end
                S_WREQ: begin
                    if (mem_req_ready) begin
                        wsel  <= W_STATUS;
                        state <= S_RREQ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the memory port, the send command and the busy flag.
    always_comb begin
        mem_req_valid = (state == S_RREQ) || (state == S_WREQ);
        mem_req_write = (state == S_WREQ);
        mem_req_wdata = (state == S_WREQ) ? cur_wb : '0;
        send_valid    = (state == S_SEND);
        send_addr     = {hi_q, lo_q};
        send_len      = cur_len;
        busy          = (state != S_IDLE);
    end
endmodule

// File: rtl/txq_fetch_engine_chk.sv
// Checker for txq_fetch_engine: handshake stability, write-back content and
// idle quietness. Attached by the bind statement at the end of this file.
module txq_fetch_engine_chk
    import txq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic                mem_req_write,
    input logic [DATA_W-1:0]   mem_req_addr,
    input logic [DATA_W-1:0]   mem_req_wdata,
    input logic                send_valid,
    input logic                send_ready,
    input logic [2*DATA_W-1:0] send_addr,
    input logic [LEN_W-1:0]    send_len,
    input logic                busy,
    input logic                fmt_err
);
    // R5
    send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid && !send_ready |=> send_valid && $stable(send_addr) && $stable(send_len));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata));

    // R6
    wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> !mem_req_wdata[OWN_BIT]);

    // R7
    err_no_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> !send_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !send_valid && !mem_req_valid && !fmt_err);

    // R3
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);
endmodule

bind txq_fetch_engine txq_fetch_engine_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .send_valid    (send_valid),
    .send_ready    (send_ready),
    .send_addr     (send_addr),
    .send_len      (send_len),
    .busy          (busy),
    .fmt_err       (fmt_err)
);

// File: tb/txq_fetch_engine_tb_top.sv
// Bench for txq_fetch_engine: memory and sender models, a table-driven ring
// run, then directed tests for reset, ownership stop, wrap, poll decode and
// base reload.
module txq_fetch_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        send_valid;
    logic        send_ready = 1'b0;
    logic [63:0] send_addr;
    logic [15:0] send_len;
    logic        send_done = 1'b0;
    logic        busy, fmt_err;

    always #2.5 clk = ~clk;

    txq_fetch_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .send_valid(send_valid), .send_ready(send_ready),
        .send_addr(send_addr), .send_len(send_len), .send_done(send_done),
        .busy(busy), .fmt_err(fmt_err)
    );

    // Word-addressed memory; byte address bits 9:2 select the word.
    logic [31:0] mem [0:255];
    logic [63:0] log_addr [0:31];
    logic [15:0] log_len  [0:31];
    int          n_sent = 0, n_err = 0, cyc = 0, dcnt = 0;
    int          n_chk = 0, n_fail = 0;

    // Memory model with ready back-pressure and one-cycle read latency.
    always @(posedge clk) begin
        cyc           <= cyc + 1;
        mem_req_ready <= (cyc % 3) != 1;
        send_ready    <= (cyc % 4) != 2;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) mem[mem_req_addr[9:2]] <= mem_req_wdata;
            else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[mem_req_addr[9:2]];
            end
        end
    end

    // Sender model: log each accepted command, signal done three cycles later.
    always @(posedge clk) begin
        send_done <= (dcnt == 1);
        if (send_valid && send_ready) begin
            log_addr[n_sent % 32] <= send_addr;
            log_len[n_sent % 32]  <= send_len;
            n_sent <= n_sent + 1;
            dcnt   <= 3;
        end else if (dcnt != 0) dcnt <= dcnt - 1;
        if (fmt_err) n_err <= n_err + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        repeat (3) @(negedge clk);
        while (busy && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(!busy, "R8 scan end", 64'(busy), 64'd0);
    endtask

    // table: {status, buffer low, buffer high, expect_sent}
    localparam logic [3:0][31:0] VEC [4] = '{
        {32'hB000_003C, 32'hA000_0000, 32'h0000_0000, 32'd1},
        {32'hA000_0064, 32'hA000_1000, 32'h0000_0000, 32'd0},
        {32'hB000_05EA, 32'hA000_2000, 32'h0000_0001, 32'd1},
        {32'hF000_0040, 32'hA000_3000, 32'h0000_0000, 32'd1}
    };

    initial begin
        int k, s0, e0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy, "R1 busy", 64'(busy), 0);
        chk(!send_valid, "R1 send_valid", 64'(send_valid), 0);
        chk(!mem_req_valid, "R1 mem_req_valid", 64'(mem_req_valid), 0);
        chk(!fmt_err, "R1 fmt_err", 64'(fmt_err), 0);

        // Table-driven ring run at base 0x1000 (word index 0)
        reg_write(8'h20, 32'h0000_1000);
        for (int i = 0; i < 4; i++) begin
            mem[i*4]   = VEC[i][3];
            mem[i*4+1] = 32'hDEAD_BEEF;
            mem[i*4+2] = VEC[i][2];
            mem[i*4+3] = VEC[i][1];
        end
        s0 = n_sent; e0 = n_err;
        reg_write(8'h38, 32'h40);
        wait_idle();
        k = s0;
        for (int i = 0; i < 4; i++) begin
            chk(mem[i*4] == (VEC[i][3] & 32'h7FFF_FFFF), "R6/R7 write-back",
                64'(mem[i*4]), 64'(VEC[i][3] & 32'h7FFF_FFFF));
            if (VEC[i][0][0]) begin
                chk(log_addr[k] == {VEC[i][1], VEC[i][2]}, "R3/R5 send_addr",
                    log_addr[k], {VEC[i][1], VEC[i][2]});
                chk(log_len[k] == VEC[i][3][15:0], "R5 send_len",
                    64'(log_len[k]), 64'(VEC[i][3][15:0]));
                k++;
            end
        end
        chk(n_sent - s0 == 3, "R7 sends skip bad descriptor", 64'(n_sent - s0), 3);
        chk(n_err - e0 == 1, "R7 fmt_err pulses", 64'(n_err - e0), 1);

        // R8: end-of-ring wrapped index to 0; re-own slot 0
        mem[0] = 32'hB000_003C; mem[2] = 32'hA000_4000; mem[3] = 32'h0;
        s0 = n_sent;
        reg_write(8'h38, 32'h40);
        wait_idle();
        chk(n_sent - s0 == 1, "R8 wrap send count", 64'(n_sent - s0), 1);
        chk(log_addr[s0] == 64'hA000_4000, "R8 wrap to slot 0", log_addr[s0], 64'hA000_4000);

        // R4: nothing owned -> no send, index stays at slot 1
        s0 = n_sent;
        reg_write(8'h38, 32'h40);
        wait_idle();
        chk(n_sent == s0, "R4 no send when not owned", 64'(n_sent - s0), 0);
        chk(mem[4] == 32'h2000_0064, "R4 status untouched", 64'(mem[4]), 64'h2000_0064);
        mem[4] = 32'hB000_0050; mem[6] = 32'hA000_5000; mem[7] = 32'h0;
        reg_write(8'h38, 32'h40);
        wait_idle();
        chk(n_sent - s0 == 1 && log_addr[s0] == 64'hA000_5000, "R4 index unchanged",
            log_addr[s0], 64'hA000_5000);
        chk(log_len[s0] == 16'h0050, "R5 len 80", 64'(log_len[s0]), 64'h50);

        // R2: wrong poll value or offset starts nothing
        mem[8] = 32'hB000_0100; mem[10] = 32'hA000_6000; mem[11] = 32'h0;
        s0 = n_sent;
        reg_write(8'h38, 32'h04);
        reg_write(8'h3C, 32'h40);
        begin
            bit seen;
            seen = 1'b0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (busy) seen = 1'b1;
            end
            chk(!seen, "R2 bad kick ignored (busy)", 64'(seen), 0);
        end
        chk(n_sent == s0, "R2 bad kick ignored (send)", 64'(n_sent - s0), 0);
        reg_write(8'h38, 32'h40);
        wait_idle();
        chk(n_sent - s0 == 1 && log_addr[s0] == 64'hA000_6000, "R2 good kick",
            log_addr[s0], 64'hA000_6000);

        // R9: base reload restarts at slot 0 of the new ring (word index 0x40)
        mem[8'h40] = 32'hB000_0200; mem[8'h42] = 32'hA000_7000; mem[8'h43] = 32'h0;
        mem[8'h44] = 32'h0;
        s0 = n_sent;
        reg_write(8'h20, 32'h0000_1105);
        reg_write(8'h38, 32'h40);
        wait_idle();
        chk(n_sent - s0 == 1 && log_addr[s0] == 64'hA000_7000, "R9 new base slot 0",
            log_addr[s0], 64'hA000_7000);
        chk(mem[8'h40] == 32'h3000_0200, "R9/R6 write-back at new base",
            64'(mem[8'h40]), 64'h3000_0200);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule